// File: doc/BRIEF.md
# Dual-Source Interrupt Vector Register

This block is a 16-bit register slave inside a serial-peripheral module. The module has two interrupt sources: a queued SPI engine and an asynchronous serial interface. Software programs an interrupt request level in the upper byte of the register and a base vector in the lower byte. Each source raises a one-cycle request pulse. The block latches the pulse as a pending flag and presents the programmed level on its request-level output while any flag is set.

When the bus runs an interrupt-acknowledge cycle, it raises the acknowledge strobe. The block then drives an 8-bit vector. Bits 7 to 1 come from the stored vector. Bit 0 names the source being serviced. The low bit is not stored, so one programmed vector yields two adjacent vectors, one per source. When both sources are pending, the SPI source is serviced first. The serial request stays pending until its own acknowledge.

Top module: `irq_vec_reg`

## Requirements
- R1: After synchronous reset the register reads 0x000F: level 0 and vector 0x0F. The vector keeps 0x0F until it is written. Both pending flags are clear.
- R2: A write with byte enable bit 1 set loads write data bits [10:8] into the level field. A write with byte enable bit 0 set loads write data bits [7:1] into the vector. Each byte changes only when its enable is set. A read returns the level in bits [10:8] and the vector in bits [7:0]; bits [15:11] read 0.
- R3: Writes to vector bit 0 have no effect, and read data bit 0 is always 1.
- R4: While the acknowledge strobe is low, the vector output is 0.
- R5: While the acknowledge strobe is high, vector output bits [7:1] equal the stored vector bits [7:1].
- R6: Vector output bit 0 is 1 when the SPI source is serviced and 0 when the serial source is serviced.
- R7: If both sources are pending at the first cycle of an acknowledge, the SPI source is serviced. The serial request stays pending and is serviced by the next acknowledge.
- R8: A request pulse sets its source's pending flag on the next clock edge. The first cycle of an acknowledge clears the flag of the serviced source. The serviced source, and so bit 0, stays fixed for the whole strobe.
- R9: The request-level output equals the programmed level while any source is pending. It is 0 when no source is pending or when the programmed level is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_be | input | 2 | Byte enables: bit 1 = level byte, bit 0 = vector byte |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data (combinational) |
| spi_req | input | 1 | SPI engine request pulse |
| sci_req | input | 1 | Serial interface request pulse |
| iack | input | 1 | Interrupt-acknowledge strobe |
| vec_out | output | 8 | Vector bus, 0 when idle |
| irq_level | output | 3 | Request level, 0 = no request |

## Verification
The bench writes each register byte on its own and writes a 1 to vector bit 0. A design that stored bit 0, or that ignored the byte enables, would read back a changed vector or a clobbered level. It raises both requests together and acknowledges twice. A design with the priority reversed would return the even vector first, and one that cleared both flags on one acknowledge would drop the request level to 0 too early. It also holds the strobe for several cycles, and sets level 0 while a request is pending. A design that re-arbitrated mid-strobe would flip bit 0 during the strobe. One that ignored the level-0 case would report a request anyway.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
    localparam int DATA_W  = 16;
    localparam int VEC_W   = 8;
    localparam int LVL_W   = 3;
    localparam int LVL_LSB = 8;
    localparam int BE_W    = DATA_W / 8;
    localparam logic [VEC_W-1:0] VEC_RST = 8'h0F;

    typedef enum logic {
        SRC_SCI = 1'b0,
        SRC_SPI = 1'b1
    } src_e;

    typedef struct packed {
        logic [LVL_W-1:0] lvl;
        logic [VEC_W-1:1] vec_hi;
    } cfg_t;

    function automatic logic [DATA_W-1:0] pack_read(input cfg_t c);
        logic [DATA_W-1:0] r;
        r = '0;
        r[LVL_LSB +: LVL_W] = c.lvl;
        r[VEC_W-1:1] = c.vec_hi;
        r[0] = 1'b1;
        return r;
    endfunction
endpackage

// File: rtl/irqv_regs.sv
module irqv_regs
    import irqv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [BE_W-1:0]   be,
    input  logic [DATA_W-1:0] wdata,
    output cfg_t              cfg
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.lvl    <= '0;
            cfg.vec_hi <= VEC_RST[VEC_W-1:1];
        end else if (wr) begin
            if (be[1]) cfg.lvl    <= wdata[LVL_LSB +: LVL_W];
            if (be[0]) cfg.vec_hi <= wdata[VEC_W-1:1];
        end
    end
endmodule

// File: rtl/irqv_arb.sv
module irqv_arb
    import irqv_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic spi_req,
    input  logic sci_req,
    input  logic iack,
    output logic spi_pend,
    output logic sci_pend,
    output src_e grant
);
    logic iack_q;
    logic ack_first;
    src_e grant_now;
    src_e grant_q;
    logic clr_spi;
    logic clr_sci;

    assign ack_first = iack & ~iack_q;
    assign grant_now = spi_pend ? SRC_SPI : SRC_SCI;
    assign grant     = ack_first ? grant_now : grant_q;
    assign clr_spi   = ack_first & (grant_now == SRC_SPI);
    assign clr_sci   = ack_first & (grant_now == SRC_SCI);

    always_ff @(posedge clk) begin
        if (rst) begin
            iack_q   <= 1'b0;
            grant_q  <= SRC_SCI;
            spi_pend <= 1'b0;
            sci_pend <= 1'b0;
        end else begin
            iack_q   <= iack;
            if (ack_first) grant_q <= grant_now;
            spi_pend <= spi_req | (spi_pend & ~clr_spi);
            sci_pend <= sci_req | (sci_pend & ~clr_sci);
        end
    end
endmodule

// File: rtl/irqv_out.sv
module irqv_out
    import irqv_pkg::*;
(
    input  cfg_t             cfg,
    input  logic             iack,
    input  src_e             grant,
    input  logic             spi_pend,
    input  logic             sci_pend,
    output logic [VEC_W-1:0] vec_out,
    output logic [LVL_W-1:0] irq_level
);
    always_comb begin
        vec_out = '0;
        if (iack) vec_out = {cfg.vec_hi, grant};
    end

    always_comb begin
        irq_level = '0;
        if (spi_pend | sci_pend) irq_level = cfg.lvl;
    end
endmodule

// File: rtl/irq_vec_reg.sv
module irq_vec_reg
    import irqv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [BE_W-1:0]   reg_be,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              spi_req,
    input  logic              sci_req,
    input  logic              iack,
    output logic [VEC_W-1:0]  vec_out,
    output logic [LVL_W-1:0]  irq_level
);
    cfg_t cfg_w;
    logic spi_pend_w;
    logic sci_pend_w;
    src_e grant_w;

    irqv_regs u_regs (
        .clk(clk), .rst(rst), .wr(reg_wr), .be(reg_be),
        .wdata(reg_wdata), .cfg(cfg_w)
    );

    irqv_arb u_arb (
        .clk(clk), .rst(rst), .spi_req(spi_req), .sci_req(sci_req),
        .iack(iack), .spi_pend(spi_pend_w), .sci_pend(sci_pend_w),
        .grant(grant_w)
    );

    irqv_out u_out (
        .cfg(cfg_w), .iack(iack), .grant(grant_w),
        .spi_pend(spi_pend_w), .sci_pend(sci_pend_w),
        .vec_out(vec_out), .irq_level(irq_level)
    );

    assign reg_rdata = pack_read(cfg_w);
endmodule

// File: rtl/irqv_checker.sv
module irqv_checker
    import irqv_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              iack,
    input logic [DATA_W-1:0] reg_rdata,
    input logic [VEC_W-1:0]  vec_out,
    input logic [LVL_W-1:0]  irq_level,
    input logic              spi_pend,
    input logic              sci_pend
);
    logic iack_d;
    always_ff @(posedge clk) begin
        if (rst) iack_d <= 1'b0;
        else     iack_d <= iack;
    end

    assert_rd_bit0_R3: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[0] == 1'b1);

    assert_bus_idle_R4: assert property (@(posedge clk) disable iff (rst)
        !iack |-> vec_out == '0);

    assert_bus_hi_R5: assert property (@(posedge clk) disable iff (rst)
        iack |-> vec_out[VEC_W-1:1] == reg_rdata[VEC_W-1:1]);

    assert_spi_first_R7: assert property (@(posedge clk) disable iff (rst)
        (iack && !iack_d && spi_pend) |-> vec_out[0]);

    assert_sci_kept_R7: assert property (@(posedge clk) disable iff (rst)
        (iack && !iack_d && spi_pend && sci_pend) |=> sci_pend);

    assert_bit0_held_R8: assert property (@(posedge clk) disable iff (rst)
        (iack && iack_d) |-> $stable(vec_out[0]));

    assert_no_req_R9: assert property (@(posedge clk) disable iff (rst)
        (!spi_pend && !sci_pend) |-> irq_level == '0);
endmodule

bind irq_vec_reg irqv_checker u_chk (
    .clk(clk), .rst(rst), .iack(iack), .reg_rdata(reg_rdata),
    .vec_out(vec_out), .irq_level(irq_level),
    .spi_pend(spi_pend_w), .sci_pend(sci_pend_w)
);

// File: tb/irq_vec_reg_tb.sv
module irq_vec_reg_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_be = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        spi_req = 1'b0;
    logic        sci_req = 1'b0;
    logic        iack = 1'b0;
    logic [7:0]  vec_out;
    logic [2:0]  irq_level;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    irq_vec_reg dut_i (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_be(reg_be),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .spi_req(spi_req), .sci_req(sci_req), .iack(iack),
        .vec_out(vec_out), .irq_level(irq_level)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] be, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_be = be; reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0; reg_be = '0;
    endtask

    task automatic pulse(input logic s, input logic c);
        @(negedge clk);
        spi_req = s; sci_req = c;
        @(posedge clk);
        @(negedge clk);
        spi_req = 1'b0; sci_req = 1'b0;
    endtask

    task automatic ack(input int len, input logic [7:0] exp, input string req);
        @(negedge clk);
        iack = 1'b1;
        #1 chk(req, {8'h0, vec_out}, {8'h0, exp});
        for (int i = 1; i < len; i++) begin
            @(negedge clk);
            #1 chk("R8 held", {8'h0, vec_out}, {8'h0, exp});
        end
        @(negedge clk);
        iack = 1'b0;
        #1 chk("R4 idle after ack", {8'h0, vec_out}, 16'h0);
    endtask

    task automatic t_reset;
        chk("R1 reset read", reg_rdata, 16'h000F);
        chk("R1 reset level", {13'h0, irq_level}, 16'h0);
        chk("R4 idle bus", {8'h0, vec_out}, 16'h0);
    endtask

    task automatic t_regs;
        wr_reg(2'b11, 16'hFB45);
        chk("R2 full write", reg_rdata, 16'h0345);
        wr_reg(2'b01, 16'h0044);
        chk("R3 bit0 write ignored", reg_rdata, 16'h0345);
        wr_reg(2'b10, 16'h0600);
        chk("R2 level byte only", reg_rdata, 16'h0645);
        wr_reg(2'b00, 16'hFFFF);
        chk("R2 no enables", reg_rdata, 16'h0645);
    endtask

    task automatic t_single;
        pulse(1'b1, 1'b0);
        chk("R9 spi pending level", {13'h0, irq_level}, 16'h6);
        ack(1, 8'h45, "R6 spi odd vector");
        chk("R8 spi cleared", {13'h0, irq_level}, 16'h0);
        pulse(1'b0, 1'b1);
        chk("R9 sci pending level", {13'h0, irq_level}, 16'h6);
        ack(1, 8'h44, "R5 sci even vector");
        chk("R8 sci cleared", {13'h0, irq_level}, 16'h0);
    endtask

    task automatic t_both;
        pulse(1'b1, 1'b1);
        ack(3, 8'h45, "R7 spi wins");
        chk("R7 sci still pending", {13'h0, irq_level}, 16'h6);
        ack(2, 8'h44, "R7 sci next");
        chk("R8 all cleared", {13'h0, irq_level}, 16'h0);
    endtask

    task automatic t_level0;
        wr_reg(2'b11, 16'h00A0);
        chk("R2 new vector", reg_rdata, 16'h00A1);
        pulse(1'b0, 1'b1);
        chk("R9 level zero", {13'h0, irq_level}, 16'h0);
        wr_reg(2'b10, 16'h0200);
        chk("R9 level restored", {13'h0, irq_level}, 16'h2);
        ack(1, 8'hA0, "R6 sci vector");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_regs();
        t_single();
        t_both();
        t_level0();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #20000;
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule